// File: doc/BRIEF.md
# Dual Gate PWM Modulator with Per-Edge Relative Delays

This block turns a programmed period and duty setting into a PWM command, then derives from it two gate-drive outputs for two switches stacked in series, called A and B. Each series position drives its parallel pair of devices from one common output. One clock cycle is one delay step; the intended clock is 200 MHz, which gives 5 ns per step and 20000 cycles at a 10 kHz switching rate. The design also covers rates up to about 20 kHz.

A signed turn-on delay and a separate signed turn-off delay shift the edges of the two outputs against each other. A positive value makes B lag A, and a negative value makes A lag B, by the magnitude in cycles. An outer balancing loop is expected to change these delays from period to period. All four settings are therefore captured only at the period boundary, so a change written mid-period never splits or duplicates an edge. No delayed edge is allowed to run past the end of its own period. Gate drivers, isolation and dead time for complementary legs are outside this block.

The settings are plain control inputs that are sampled when the period wraps. There is no stream traffic, so there is no valid/ready handshake and no back-pressure. The three outputs are registered.

Top module: `pwm_edge_dly`

## Requirements
- R1: With a captured period P of at least 2, the internal count runs 0 to P-1 and wraps. The output prd_start is high for exactly the cycle in which the count is 0, and it repeats every P cycles.
- R2: Let Dc = min(duty, P). With both delays zero and 0 < Dc < P, gate_a and gate_b are both high in count cycles 0 to Dc-1 and low otherwise.
- R3: The turn-on edge of a pulse is delayed as follows. For dly_on = n >= 0, gate_a rises at count 0 and gate_b at count n. For n < 0, gate_b rises at count 0 and gate_a at count |n|. The values are two's complement.
- R4: The turn-off edge is delayed as follows. For dly_off = m >= 0, gate_a falls at count Dc and gate_b at count Dc+m. For m < 0, gate_b falls at count Dc and gate_a at count Dc+|m|.
- R5: A duty of 0 keeps both gates low for the whole period, whatever the delays.
- R6: A duty of P or more keeps both gates high for the whole period, whatever the delays.
- R7: A delayed edge is clamped so it never passes the end of its period. A turn-on count beyond P becomes P, and a turn-off count beyond P becomes P. A gate whose clamped turn-on count is not below its turn-off count stays low for that period.
- R8: prd_len, duty, dly_on and dly_off are sampled only on the clock edge that starts a period. Changes made at any other time have no effect until the next period starts.
- R9: While rst_n is low, all outputs are low. The first rising clock edge after release samples the inputs and starts a period, with prd_start high in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock, one delay step per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| prd_len | input | CNT_W | Period length P in cycles (2 or more) |
| duty | input | CNT_W | Command high time in cycles |
| dly_on | input | DLY_W | Signed relative turn-on delay (positive: B lags) |
| dly_off | input | DLY_W | Signed relative turn-off delay (positive: B lags) |
| gate_a | output | 1 | Gate command for series position A |
| gate_b | output | 1 | Gate command for series position B |
| prd_start | output | 1 | High in the first cycle of every period |

## Verification
The risky coincidence is the period reload landing in the same cycle as a delayed edge. The edge may be a turn-off clamped to the period end, or a new turn-on at count 0 with a different delay sign. The bench produces it by rewriting all four settings at the start of every period, sweeping delays past the period length, and then checking each cycle of the period that follows. The current period must keep the old settings and its edges must stop at the boundary. The next period must start cleanly with the new settings and a single strobe. Expected outputs come from the arithmetic rules in R2 to R7, evaluated for every cycle of every period.

// File: rtl/pwm_edge_dly_pkg.sv
package pwm_edge_dly_pkg;

  // Which series position a gate channel serves
  typedef enum logic {
    SW_A = 1'b0,
    SW_B = 1'b1
  } sw_sel_e;

endpackage

// File: rtl/pwm_edge_frame.sv
// Period counter plus shadow copies of the settings, reloaded at the wrap.
module pwm_edge_frame #(
  parameter int CNT_W = 16,
  parameter int DLY_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-1:0]        prd_len,
  input  logic [CNT_W-1:0]        duty,
  input  logic signed [DLY_W-1:0] dly_on,
  input  logic signed [DLY_W-1:0] dly_off,
  output logic [CNT_W-1:0]        cnt_nx,
  output logic [CNT_W-1:0]        prd_nx,
  output logic [CNT_W-1:0]        duty_nx,
  output logic signed [DLY_W-1:0] don_nx,
  output logic signed [DLY_W-1:0] doff_nx,
  output logic [CNT_W-1:0]        prd_q,
  output logic [CNT_W-1:0]        duty_q,
  output logic                    don_neg_q,
  output logic                    doff_neg_q,
  output logic                    prd_start
);

  localparam int XW = CNT_W + 1;

  logic [CNT_W-1:0]        cnt_q;
  logic signed [DLY_W-1:0] don_q;
  logic signed [DLY_W-1:0] doff_q;
  logic                    wrap;

  always_comb begin
    wrap    = (XW'(cnt_q) + XW'(1)) >= XW'(prd_q);
    cnt_nx  = wrap ? '0 : cnt_q + CNT_W'(1);
    prd_nx  = wrap ? prd_len : prd_q;
    duty_nx = wrap ? duty    : duty_q;
    don_nx  = wrap ? dly_on  : don_q;
    doff_nx = wrap ? dly_off : doff_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      prd_q     <= '0;
      duty_q    <= '0;
      don_q     <= '0;
      doff_q    <= '0;
      prd_start <= 1'b0;
    end else begin
      cnt_q     <= cnt_nx;
      prd_q     <= prd_nx;
      duty_q    <= duty_nx;
      don_q     <= don_nx;
      doff_q    <= doff_nx;
      prd_start <= wrap;
    end
  end

  assign don_neg_q  = don_q[DLY_W-1];
  assign doff_neg_q = doff_q[DLY_W-1];

  // R1: the count stays inside the captured period
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_q >= CNT_W'(2)) |-> (cnt_q < prd_q));

  // R1: a strobe is a single cycle when the period is two or longer
  p_start_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_start && prd_q >= CNT_W'(2)) |=> !prd_start);

  // R8: settings are frozen between period boundaries
  p_hold_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(prd_q) && $stable(duty_q) && $stable(don_q) && $stable(doff_q)));

endmodule

// File: rtl/pwm_edge_plan.sv
// Turns the captured settings into turn-on/turn-off counts for one switch.
module pwm_edge_plan
  import pwm_edge_dly_pkg::*;
#(
  parameter int      CNT_W = 16,
  parameter int      DLY_W = 8,
  parameter sw_sel_e SW    = SW_A
) (
  input  logic [CNT_W-1:0]        prd,
  input  logic [CNT_W-1:0]        duty,
  input  logic signed [DLY_W-1:0] don,
  input  logic signed [DLY_W-1:0] doff,
  output logic [CNT_W:0]          on_thr,
  output logic [CNT_W:0]          off_thr
);

  localparam int TW = CNT_W + 1;
  localparam int WW = ((TW > DLY_W) ? TW : DLY_W) + 1;

  logic [DLY_W-1:0] on_mag, off_mag;
  logic             on_lags, off_lags;
  logic [WW-1:0]    p_w, dc_w, lon_w, loff_w, sum_w, on_w, off_w;

  always_comb begin
    on_mag  = don[DLY_W-1]  ? DLY_W'(-don)  : DLY_W'(don);
    off_mag = doff[DLY_W-1] ? DLY_W'(-doff) : DLY_W'(doff);
    // B lags on a positive setting, A lags on a negative one
    on_lags  = (SW == SW_B) ? !don[DLY_W-1]  : don[DLY_W-1];
    off_lags = (SW == SW_B) ? !doff[DLY_W-1] : doff[DLY_W-1];

    p_w    = WW'(prd);
    dc_w   = (duty > prd) ? WW'(prd) : WW'(duty);
    lon_w  = on_lags  ? WW'(on_mag)  : '0;
    loff_w = off_lags ? WW'(off_mag) : '0;
    sum_w  = dc_w + loff_w;
    on_w   = (lon_w > p_w) ? p_w : lon_w;
    off_w  = (sum_w > p_w) ? p_w : sum_w;

    if (dc_w == '0) begin
      on_thr  = '0;
      off_thr = '0;
    end else if (dc_w == p_w) begin
      on_thr  = '0;
      off_thr = TW'(p_w);
    end else begin
      on_thr  = TW'(on_w);
      off_thr = TW'(off_w);
    end
  end

endmodule

// File: rtl/pwm_edge_gate.sv
// Registered gate output, computed from next-state count and thresholds.
module pwm_edge_gate #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_nx,
  input  logic [CNT_W:0]   on_thr,
  input  logic [CNT_W:0]   off_thr,
  output logic             gate
);

  localparam int TW = CNT_W + 1;

  logic [TW-1:0] cnt_w;
  logic          gate_nx;

  always_comb begin
    cnt_w   = TW'(cnt_nx);
    gate_nx = (cnt_w >= on_thr) && (cnt_w < off_thr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) gate <= 1'b0;
    else        gate <= gate_nx;
  end

endmodule

// File: rtl/pwm_edge_dly.sv
module pwm_edge_dly
  import pwm_edge_dly_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DLY_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-1:0]        prd_len,
  input  logic [CNT_W-1:0]        duty,
  input  logic signed [DLY_W-1:0] dly_on,
  input  logic signed [DLY_W-1:0] dly_off,
  output logic                    gate_a,
  output logic                    gate_b,
  output logic                    prd_start
);

  localparam int NSW = 2;

  logic [CNT_W-1:0]        cnt_nx, prd_nx, duty_nx, prd_q, duty_q;
  logic signed [DLY_W-1:0] don_nx, doff_nx;
  logic                    don_neg_q, doff_neg_q;
  logic [NSW-1:0]          gate_v;

  pwm_edge_frame #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .prd_len    (prd_len),
    .duty       (duty),
    .dly_on     (dly_on),
    .dly_off    (dly_off),
    .cnt_nx     (cnt_nx),
    .prd_nx     (prd_nx),
    .duty_nx    (duty_nx),
    .don_nx     (don_nx),
    .doff_nx    (doff_nx),
    .prd_q      (prd_q),
    .duty_q     (duty_q),
    .don_neg_q  (don_neg_q),
    .doff_neg_q (doff_neg_q),
    .prd_start  (prd_start)
  );

  for (genvar g = 0; g < NSW; g++) begin : g_sw
    localparam sw_sel_e SW_G = (g == 0) ? SW_A : SW_B;
    logic [CNT_W:0] on_thr, off_thr;

    pwm_edge_plan #(.CNT_W(CNT_W), .DLY_W(DLY_W), .SW(SW_G)) u_plan (
      .prd     (prd_nx),
      .duty    (duty_nx),
      .don     (don_nx),
      .doff    (doff_nx),
      .on_thr  (on_thr),
      .off_thr (off_thr)
    );

    pwm_edge_gate #(.CNT_W(CNT_W)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_nx  (cnt_nx),
      .on_thr  (on_thr),
      .off_thr (off_thr),
      .gate    (gate_v[g])
    );
  end

  assign gate_a = gate_v[0];
  assign gate_b = gate_v[1];

  // R5: zero duty keeps both switches off
  p_zero_duty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> (!gate_a && !gate_b));

  // R6: full duty keeps both switches on
  p_full_duty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_q != '0 && duty_q >= prd_q) |-> (gate_a && gate_b));

  // R3: with a non-negative turn-on setting, A never turns on mid-period
  p_on_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!don_neg_q && !prd_start) |-> !$rose(gate_a));

  // R4: with a non-negative turn-off setting, B is never the first to turn off
  p_off_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!doff_neg_q && !prd_start && $fell(gate_b)) |-> !gate_a);

endmodule

// File: tb/pwm_edge_dly_bench.sv
module pwm_edge_dly_bench;

  localparam int CW = 4;
  localparam int DW = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [CW-1:0]        prd_len = '0;
  logic [CW-1:0]        duty = '0;
  logic signed [DW-1:0] dly_on = '0;
  logic signed [DW-1:0] dly_off = '0;
  logic                 gate_a, gate_b, prd_start;

  always #5 clk = ~clk;

  pwm_edge_dly #(.CNT_W(CW), .DLY_W(DW)) u_pwm_edge_dly (
    .clk(clk), .rst_n(rst_n), .prd_len(prd_len), .duty(duty),
    .dly_on(dly_on), .dly_off(dly_off),
    .gate_a(gate_a), .gate_b(gate_b), .prd_start(prd_start)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int cur_p, cur_d, cur_on, cur_off;

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual={start,a,b}=%b expected=%b", tag, act, exp);
    end
  endtask

  // Expected gate level in count cycle k, from R2..R7
  function automatic bit exp_gate(bit is_b, int p, int d, int don, int doff, int k);
    int dc, lon, loff, on_c, off_c;
    dc = (d > p) ? p : d;
    if (dc == 0) return 1'b0;
    if (dc == p) return 1'b1;
    lon  = is_b ? ((don > 0) ? don : 0)   : ((don < 0) ? -don : 0);
    loff = is_b ? ((doff > 0) ? doff : 0) : ((doff < 0) ? -doff : 0);
    on_c  = (lon > p) ? p : lon;
    off_c = (dc + loff > p) ? p : dc + loff;
    return (k >= on_c) && (k < off_c);
  endfunction

  function automatic string tag_of(int p, int d, int don, int doff);
    string s;
    s = "R1";
    if (d == 0) s = {s, " R5"};
    else if (d >= p) s = {s, " R6"};
    else begin
      if (don == 0 && doff == 0) s = {s, " R2"};
      else s = {s, " R3 R4"};
      if ((don > 0 ? don : -don) >= p || d + (doff > 0 ? doff : -doff) > p) s = {s, " R7"};
    end
    return s;
  endfunction

  // Called at the negedge of count 0; returns at the negedge of the next count 0
  task automatic check_period(input string extra);
    string tag;
    tag = {tag_of(cur_p, cur_d, cur_on, cur_off), extra};
    for (int k = 0; k < cur_p; k++) begin
      chk($sformatf("%s p=%0d d=%0d on=%0d off=%0d k=%0d", tag, cur_p, cur_d, cur_on, cur_off, k),
          {prd_start, gate_a, gate_b},
          {(k == 0), exp_gate(1'b0, cur_p, cur_d, cur_on, cur_off, k),
                     exp_gate(1'b1, cur_p, cur_d, cur_on, cur_off, k)});
      @(negedge clk);
    end
  endtask

  // New settings written mid-period; R8: the running period keeps the old ones
  task automatic step(input int p, input int d, input int on, input int off);
    prd_len = CW'(p);
    duty    = CW'(d);
    dly_on  = DW'(on);
    dly_off = DW'(off);
    check_period(" R8");
    cur_p = p; cur_d = d; cur_on = on; cur_off = off;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    cur_p = 5; cur_d = 2; cur_on = 0; cur_off = 0;
    prd_len = CW'(cur_p);
    duty    = CW'(cur_d);
    repeat (3) @(negedge clk);
    // R9: outputs low during reset
    chk("R9 reset", {prd_start, gate_a, gate_b}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: first period begins immediately after release
    chk("R9 first strobe", {prd_start, 2'b00}, 3'b100);
    check_period(" R9");
    for (int p = 2; p <= 7; p++) begin
      if (p == 2 || p == 5 || p == 7) begin
        for (int d = 0; d <= p + 1; d++)
          for (int on = -4; on <= 4; on++)
            for (int off = -4; off <= 4; off++)
              step(p, d, on, off);
      end
    end
    check_period("");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule